// File: doc/BRIEF.md
# Layered Pong Playfield Renderer

This block turns the current scan position into a 3-bit colour for a pong playfield. It also owns the vertical position of the left paddle. Five layers are stacked from the bottom up: a black background, a green checkerboard table, a white midline, a black net and a blue paddle. Each shape generator produces a colour together with a flag that says whether the shape covers the pixel. A chain of two-input mixers lets the higher layer win wherever its flag is set.

The colour output is combinational from the scan coordinates, the active-area flag and the registered paddle position. The paddle controller samples a single pushbutton on each frame tick. A held button moves the paddle down by two rows, and a released button moves it up by two rows. A candidate position that would leave the legal range is discarded, so the paddle keeps its previous value. The scan timing generator and the ball logic are outside this block.

Top module: `pong_field_render`

## Requirements
- R1: While `active` is low, `rgb` is 3'b000 (black) whatever the coordinates and the paddle position.
- R2: In the active area, a pixel covered by no shape (y below 40 or above 439, away from the paddle) is black, 3'b000.
- R3: For y in 40..439, where no higher layer covers the pixel, `rgb` is green (3'b010) when x[3] XOR y[3] is 1 and black (3'b000) when it is 0, giving 8x8 squares.
- R4: Rows y = 239 and y = 240 are white (3'b111) at every active x not covered by the net or the paddle. The midline covers the table.
- R5: Columns x = 318..321 are black (3'b000) for y in 40..439. The net covers both the midline and the table.
- R6: The paddle is blue (3'b001) at x = 16..25 and y from `paddle_y` to `paddle_y`+49 inclusive. It covers every other layer.
- R7: After reset, `paddle_y` is 214.
- R8: On a clock edge with `frame_tick` high, `paddle_y` increases by 2 if `btn_down` is high and decreases by 2 if it is low. Without `frame_tick`, `paddle_y` does not change.
- R9: A candidate position below 0 or above 430 is rejected and `paddle_y` keeps its old value. For example, up from 0 stays at 0 and down from 430 stays at 430.
- R10: `paddle_y` never leaves the range 0..430.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle pulse per frame that allows a paddle move |
| btn_down | input | 1 | Paddle button: high moves down, low moves up |
| active | input | 1 | High inside the visible display area |
| px_x | input | 10 | Current pixel column |
| px_y | input | 10 | Current pixel row |
| rgb | output | 3 | Pixel colour {r,g,b} |
| paddle_y | output | 10 | Top row of the left paddle |

## Verification
A paddle register that drifts shows up directly on `paddle_y` in the cycle after the next frame tick. It also shows one frame later as blue pixels in the wrong rows of columns 16..25. A wrong priority order among the mixers is visible within the same pixel, wherever two layers overlap: midline under the net, net over the table, paddle over the midline. A wrong range gate only appears once the paddle has been walked to 0 or to 430 and pushed one step further, so the runs drive it all the way to both ends.

// File: rtl/pong_pkg.sv
package pong_pkg;
  typedef logic [2:0] rgb_t;

  localparam rgb_t C_BLACK = 3'b000;
  localparam rgb_t C_GREEN = 3'b010;
  localparam rgb_t C_WHITE = 3'b111;
  localparam rgb_t C_BLUE  = 3'b001;

  // one drawing layer: colour and coverage flag
  typedef struct packed {
    rgb_t col;
    logic vld;
  } layer_t;

  // layers above the background, lowest priority first
  localparam int N_LAYERS = 4;
  localparam int L_TABLE  = 0;
  localparam int L_MID    = 1;
  localparam int L_NET    = 2;
  localparam int L_PAD    = 3;
endpackage

// File: rtl/pf_layer_mix.sv
module pf_layer_mix
  import pong_pkg::*;
(
  input  layer_t lo_i,
  input  layer_t hi_i,
  output layer_t mix_o
);
  always_comb begin
    if (hi_i.vld) mix_o = hi_i;
    else          mix_o = lo_i;
  end
endmodule

// File: rtl/pf_shapes.sv
module pf_shapes
  import pong_pkg::*;
#(
  parameter int XW       = 10,
  parameter int YW       = 10,
  parameter int TAB_Y0   = 40,
  parameter int TAB_Y1   = 439,
  parameter int MID_Y0   = 239,
  parameter int MID_H    = 2,
  parameter int NET_X0   = 318,
  parameter int NET_W    = 4,
  parameter int PAD_X0   = 16,
  parameter int PAD_W    = 10,
  parameter int PAD_H    = 50,
  parameter int CHK_BIT  = 3
)(
  input  logic [XW-1:0]       x_i,
  input  logic [YW-1:0]       y_i,
  input  logic [YW-1:0]       pad_y_i,
  output layer_t [N_LAYERS-1:0] lay_o
);
  localparam logic [YW-1:0] TY0 = YW'(TAB_Y0);
  localparam logic [YW-1:0] TY1 = YW'(TAB_Y1);
  localparam logic [YW-1:0] MY0 = YW'(MID_Y0);
  localparam logic [YW-1:0] MY1 = YW'(MID_Y0 + MID_H - 1);
  localparam logic [XW-1:0] NX0 = XW'(NET_X0);
  localparam logic [XW-1:0] NX1 = XW'(NET_X0 + NET_W - 1);
  localparam logic [XW-1:0] PX0 = XW'(PAD_X0);
  localparam logic [XW-1:0] PX1 = XW'(PAD_X0 + PAD_W - 1);
  localparam logic [YW:0]   PDY = (YW+1)'(PAD_H - 1);

  logic in_table, in_mid, in_net, in_pad, chk;
  logic [YW:0] pad_bot;

  always_comb begin
    in_table = (y_i >= TY0) && (y_i <= TY1);
    in_mid   = (y_i >= MY0) && (y_i <= MY1);
    in_net   = (x_i >= NX0) && (x_i <= NX1) && in_table;
    pad_bot  = {1'b0, pad_y_i} + PDY;
    in_pad   = (x_i >= PX0) && (x_i <= PX1) &&
               (y_i >= pad_y_i) && ({1'b0, y_i} <= pad_bot);
    chk      = x_i[CHK_BIT] ^ y_i[CHK_BIT];

    lay_o[L_TABLE] = '{col: (chk ? C_GREEN : C_BLACK), vld: in_table};
    lay_o[L_MID]   = '{col: C_WHITE, vld: in_mid};
    lay_o[L_NET]   = '{col: C_BLACK, vld: in_net};
    lay_o[L_PAD]   = '{col: C_BLUE,  vld: in_pad};
  end
endmodule

// File: rtl/pf_paddle_ctrl.sv
module pf_paddle_ctrl #(
  parameter int YW      = 10,
  parameter int STEP    = 2,
  parameter int Y_MAX   = 430,
  parameter int Y_RESET = 214
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          down_i,
  output logic [YW-1:0] pad_y_o
);
  localparam int CW = YW + 2;
  localparam logic signed [CW-1:0] STEP_S = CW'(STEP);
  localparam logic signed [CW-1:0] MAX_S  = CW'(Y_MAX);
  localparam logic [YW-1:0]        RST_V  = YW'(Y_RESET);

  logic [YW-1:0]        pad_q, pad_d;
  logic signed [CW-1:0] cand;
  logic                 in_range;
  logic                 upd_en;

  always_comb begin
    cand     = $signed({2'b00, pad_q}) + (down_i ? STEP_S : -STEP_S);
    in_range = !cand[CW-1] && (cand <= MAX_S);
    upd_en   = tick_i && in_range;
    pad_d    = cand[YW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pad_q <= RST_V;
    else if (upd_en) pad_q <= pad_d;
  end

  assign pad_y_o = pad_q;
endmodule

// File: rtl/pong_field_render.sv
module pong_field_render
  import pong_pkg::*;
#(
  parameter int XW = 10,
  parameter int YW = 10
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          frame_tick,
  input  logic          btn_down,
  input  logic          active,
  input  logic [XW-1:0] px_x,
  input  logic [YW-1:0] px_y,
  output logic [2:0]    rgb,
  output logic [YW-1:0] paddle_y
);
  layer_t [N_LAYERS-1:0] lay;
  layer_t [N_LAYERS:0]   stage;

  pf_paddle_ctrl #(.YW(YW)) u_pad (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (frame_tick),
    .down_i  (btn_down),
    .pad_y_o (paddle_y)
  );

  pf_shapes #(.XW(XW), .YW(YW)) u_shapes (
    .x_i     (px_x),
    .y_i     (px_y),
    .pad_y_i (paddle_y),
    .lay_o   (lay)
  );

  assign stage[0] = '{col: C_BLACK, vld: 1'b1};

  for (genvar i = 0; i < N_LAYERS; i++) begin : g_mix
    pf_layer_mix u_mix (
      .lo_i  (stage[i]),
      .hi_i  (lay[i]),
      .mix_o (stage[i+1])
    );
  end

  assign rgb = active ? stage[N_LAYERS].col : C_BLACK;
endmodule

// File: rtl/pf_checker.sv
module pf_checker #(
  parameter int XW = 10,
  parameter int YW = 10
)(
  input logic          clk,
  input logic          rst_n,
  input logic          frame_tick,
  input logic          btn_down,
  input logic          active,
  input logic [XW-1:0] px_x,
  input logic [YW-1:0] px_y,
  input logic [2:0]    rgb,
  input logic [YW-1:0] paddle_y
);
  a_r1_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> rgb == 3'b000);

  a_r6_paddle_blue: assert property (@(posedge clk) disable iff (!rst_n)
    (active && px_x >= 16 && px_x <= 25 && px_y >= paddle_y &&
     {1'b0, px_y} <= {1'b0, paddle_y} + 11'd49) |-> rgb == 3'b001);

  a_r8_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_tick |=> $stable(paddle_y));

  a_r8_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && btn_down && paddle_y <= 428) |=> paddle_y == $past(paddle_y) + 10'd2);

  a_r8_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !btn_down && paddle_y >= 2) |=> paddle_y == $past(paddle_y) - 10'd2);

  a_r9_reject_low: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && !btn_down && paddle_y < 2) |=> $stable(paddle_y));

  a_r9_reject_high: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_tick && btn_down && paddle_y > 428) |=> $stable(paddle_y));

  a_r10_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    paddle_y <= 430);
endmodule

bind pong_field_render pf_checker #(.XW(XW), .YW(YW)) u_pf_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_tick (frame_tick),
  .btn_down   (btn_down),
  .active     (active),
  .px_x       (px_x),
  .px_y       (px_y),
  .rgb        (rgb),
  .paddle_y   (paddle_y)
);

// File: tb/pong_field_render_bench.sv
module pong_field_render_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       frame_tick, btn_down, active;
  logic [9:0] px_x, px_y;
  logic [2:0] rgb;
  logic [9:0] paddle_y;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  pong_field_render u_pong_field_render (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .btn_down(btn_down),
    .active(active), .px_x(px_x), .px_y(px_y), .rgb(rgb), .paddle_y(paddle_y)
  );

  task automatic check(string req, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic pix(string req, int x, int y, logic act, logic [2:0] exp);
    @(negedge clk);
    px_x = 10'(x); px_y = 10'(y); active = act;
    #1;
    check(req, int'(rgb), int'(exp));
  endtask

  task automatic tick(logic dn);
    @(negedge clk);
    frame_tick = 1'b1; btn_down = dn;
    @(negedge clk);
    frame_tick = 1'b0;
  endtask

  task automatic t_reset();
    check("R7 reset position", int'(paddle_y), 214);
  endtask

  task automatic t_blank();
    pix("R1 blank over midline", 104, 239, 1'b0, 3'b000);
    pix("R1 blank over paddle", 20, 239, 1'b0, 3'b000);
    pix("R1 blank over table", 0, 40, 1'b0, 3'b000);
  endtask

  task automatic t_background();
    pix("R2 above table", 104, 39, 1'b1, 3'b000);
    pix("R2 below table", 104, 440, 1'b1, 3'b000);
    pix("R2 far corner", 600, 470, 1'b1, 3'b000);
  endtask

  task automatic t_stipple();
    pix("R3 green square", 0, 40, 1'b1, 3'b010);
    pix("R3 black square", 8, 40, 1'b1, 3'b000);
    pix("R3 green square 2", 8, 48, 1'b1, 3'b010);
    pix("R3 bottom black", 100, 439, 1'b1, 3'b000);
    pix("R3 bottom green", 104, 439, 1'b1, 3'b010);
  endtask

  task automatic t_midline();
    pix("R4 midline top row", 104, 239, 1'b1, 3'b111);
    pix("R4 midline bottom row", 104, 240, 1'b1, 3'b111);
    pix("R4 below midline", 104, 241, 1'b1, 3'b010);
    pix("R4 above midline", 104, 238, 1'b1, 3'b000);
  endtask

  task automatic t_net();
    pix("R5 net over midline", 318, 239, 1'b1, 3'b000);
    pix("R5 net over green", 318, 48, 1'b1, 3'b000);
    pix("R5 net right edge", 321, 240, 1'b1, 3'b000);
    pix("R5 left of net", 317, 239, 1'b1, 3'b111);
    pix("R5 right of net", 322, 239, 1'b1, 3'b111);
    pix("R5 next to net green", 317, 48, 1'b1, 3'b010);
  endtask

  task automatic t_paddle(int py);
    pix("R6 paddle top row", 20, py, 1'b1, 3'b001);
    pix("R6 paddle right edge", 25, py + 49, 1'b1, 3'b001);
    pix("R6 paddle left edge", 16, py + 10, 1'b1, 3'b001);
    pix("R6 right of paddle", 26, py + 10, 1'b1, (((26 ^ (py + 10)) & 8) != 0) ? 3'b010 : 3'b000);
    pix("R6 left of paddle", 15, py + 10, 1'b1, (((15 ^ (py + 10)) & 8) != 0) ? 3'b010 : 3'b000);
    pix("R6 below paddle", 20, py + 50, 1'b1, (((20 ^ (py + 50)) & 8) != 0) ? 3'b010 : 3'b000);
  endtask

  task automatic t_midline_paddle();
    pix("R6 paddle over midline", 20, 239, 1'b1, 3'b001);
    pix("R6 midline beside paddle", 26, 239, 1'b1, 3'b111);
  endtask

  task automatic t_move();
    tick(1'b1);
    check("R8 step down", int'(paddle_y), 216);
    @(negedge clk); btn_down = 1'b1;
    repeat (3) @(negedge clk);
    check("R8 no tick hold", int'(paddle_y), 216);
    tick(1'b0);
    check("R8 step up", int'(paddle_y), 214);
  endtask

  task automatic t_limits();
    for (int i = 0; i < 107; i++) tick(1'b0);
    check("R10 reach top", int'(paddle_y), 0);
    tick(1'b0);
    check("R9 reject below 0", int'(paddle_y), 0);
    t_paddle(0);
    for (int i = 0; i < 215; i++) tick(1'b1);
    check("R10 reach bottom", int'(paddle_y), 430);
    tick(1'b1);
    check("R9 reject above 430", int'(paddle_y), 430);
    t_paddle(430);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; frame_tick = 1'b0; btn_down = 1'b0; active = 1'b0;
    px_x = '0; px_y = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_blank();
    t_background();
    t_stipple();
    t_midline();
    t_net();
    t_midline_paddle();
    t_paddle(214);
    t_move();
    t_limits();
    finish_run();
  end
endmodule